// File: doc/BRIEF.md
# Router Bank Idleness History Table

This block sits inside one mesh router and remembers, for every memory bank in the system, when this router last forwarded a request toward it. When a candidate request's head flit asks about its target bank, the table answers whether that bank has gone without traffic from this router for a full history window. A bank in that state is inferred to be idle, and the request is flagged so that the router's arbiters can favour it. The aim is to spread requests across banks and keep them busy, using only what the router itself has seen.

Each bank entry holds a valid bit and the value of a free-running wrap-around cycle counter, captured when the last request was forwarded. A bank is idle when its entry is invalid or its age, measured against the counter, has reached the window length. A background sweep visits one entry per cycle and clears entries that have already aged out. Because of this, a stale stamp never aliases onto a recent counter value after the counter wraps. The window length is a parameter; 100, 200 and 400 cycles are the intended settings.

Top module: `bank_idle_table`

## Requirements
- R1: After reset every bank reads as idle: a head-flit lookup of any bank returns a result with the prioritize flag at 1.
- R2: A lookup presented k cycles after a head-flit update of the same bank, with 1 <= k <= WINDOW-1, returns the flag at 0.
- R3: A lookup presented exactly WINDOW cycles after the last head-flit update of that bank returns the flag at 1.
- R4: An update strobe whose head indicator is 0 (body or tail flit) leaves the table unchanged.
- R5: A lookup strobe whose head indicator is 0 produces no result; a head-flit lookup produces exactly one result, in the following cycle.
- R6: When a lookup and an update name the same bank in the same cycle, the lookup reports the state from before that update.
- R7: An update affects only the entry of the bank it names.
- R8: A repeated update of a bank restarts its window from the latest update.
- R9: A bank whose last update lies more than one counter wrap in the past reads as idle, with no aliasing.
- R10: Each result carries the bank index of the lookup that produced it, and lookups presented on consecutive cycles produce results on consecutive cycles in the same order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | A request flit is forwarded this cycle |
| upd_head | input | 1 | The forwarded flit is a head flit |
| upd_bank | input | BANK_W | Global bank index of the forwarded request |
| lk_valid | input | 1 | Candidate flit presented for lookup |
| lk_head | input | 1 | Candidate flit is a head flit |
| lk_bank | input | BANK_W | Global bank index targeted by the candidate |
| res_valid | output | 1 | Lookup result is valid this cycle |
| res_bank | output | BANK_W | Bank index the result belongs to |
| res_prio | output | 1 | 1 when the bank is idle and the request should be prioritized |

## Verification
The assertions check several properties on every cycle. No valid entry ever ages past the window plus one sweep round, so wrap aliasing cannot happen. An entry becomes valid only through a head update that names it. Results follow head lookups exactly one cycle later. A lookup that collides with an update of an idle bank still reports idle, and a lookup that directly follows an update reports busy. Only the bench's scenarios show the exact window edges (WINDOW-1 busy, WINDOW idle), window restart on re-update, idleness after a full counter wrap, isolation between banks, and ordered results from back-to-back lookups.

// File: rtl/bht_pkg.sv
package bht_pkg;

    localparam int unsigned DEF_NUM_BANKS = 64;
    localparam int unsigned DEF_WINDOW    = 200;

    // What happens to one table entry in a given cycle
    typedef enum logic [1:0] {
        ENT_HOLD  = 2'd0,
        ENT_LOAD  = 2'd1,
        ENT_CLEAR = 2'd2
    } ent_action_e;

    // Width of the wrap-around time counter: must exceed the longest age
    // a valid entry can reach (window plus one full sweep round).
    function automatic int unsigned time_width(input int unsigned window,
                                               input int unsigned banks);
        return $clog2(window + banks) + 1;
    endfunction

    // Age is already reduced modulo the counter width by the caller.
    function automatic logic age_expired(input int unsigned age,
                                         input int unsigned window);
        return age >= window;
    endfunction

endpackage

// File: rtl/bht_timebase.sv
module bht_timebase #(
    parameter int unsigned NUM_BANKS = bht_pkg::DEF_NUM_BANKS,
    parameter int unsigned CNT_W     = 10,
    localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    output logic [CNT_W-1:0]  now,
    output logic [BANK_W-1:0] sweep_ptr
);

    localparam logic [BANK_W-1:0] LAST_IDX = BANK_W'(NUM_BANKS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            now       <= '0;
            sweep_ptr <= '0;
        end else begin
            now <= now + 1'b1;
            if (sweep_ptr == LAST_IDX)
                sweep_ptr <= '0;
            else
                sweep_ptr <= sweep_ptr + 1'b1;
        end
    end

    a_r9_sweep_in_range: assert property (@(posedge clk) disable iff (rst)
        sweep_ptr <= LAST_IDX);

    a_r3_time_advances: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> now == CNT_W'($past(now) + 1'b1));

endmodule

// File: rtl/bht_entry.sv
module bht_entry #(
    parameter int unsigned NUM_BANKS = bht_pkg::DEF_NUM_BANKS,
    parameter int unsigned WINDOW    = bht_pkg::DEF_WINDOW,
    parameter int unsigned CNT_W     = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] now,
    input  logic             hit,        // head update names this bank
    input  logic             swept,      // sweep pointer is on this entry
    output logic             valid_q,
    output logic [CNT_W-1:0] stamp_q
);
    import bht_pkg::*;

    logic [CNT_W-1:0] age;
    ent_action_e      action;

    assign age = now - stamp_q;

    always_comb begin
        if (hit)
            action = ENT_LOAD;
        else if (swept && valid_q && age_expired(int'(age), WINDOW))
            action = ENT_CLEAR;
        else
            action = ENT_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            stamp_q <= '0;
        end else begin
            unique case (action)
                ENT_LOAD: begin
                    valid_q <= 1'b1;
                    stamp_q <= now;
                end
                ENT_CLEAR: valid_q <= 1'b0;
                default: ;
            endcase
        end
    end

    // R9: sweep keeps every live stamp within one window plus one sweep round
    a_r9_stale_bounded: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> int'(age) < int'(WINDOW + NUM_BANKS));

    // R4/R7: an entry only becomes valid through a head update naming it
    a_r4_set_needs_hit: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_q) |-> $past(hit));

endmodule

// File: rtl/bht_lookup.sv
module bht_lookup #(
    parameter int unsigned NUM_BANKS = bht_pkg::DEF_NUM_BANKS,
    parameter int unsigned WINDOW    = bht_pkg::DEF_WINDOW,
    parameter int unsigned CNT_W     = 10,
    localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [CNT_W-1:0]                now,
    input  logic [NUM_BANKS-1:0]            valid_vec,
    input  logic [NUM_BANKS-1:0][CNT_W-1:0] stamp_vec,
    input  logic                            fire,
    input  logic [BANK_W-1:0]               bank,
    output logic                            res_valid,
    output logic [BANK_W-1:0]               res_bank,
    output logic                            res_prio
);
    import bht_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [BANK_W-1:0] bank;
        logic              prio;
    } result_t;

    logic             sel_valid;
    logic [CNT_W-1:0] sel_stamp;
    logic [CNT_W-1:0] sel_age;
    logic             idle;
    result_t          res_q;

    always_comb begin
        sel_valid = 1'b0;
        sel_stamp = '0;
        if (int'(bank) < int'(NUM_BANKS)) begin
            sel_valid = valid_vec[bank];
            sel_stamp = stamp_vec[bank];
        end
    end

    assign sel_age = now - sel_stamp;
    assign idle    = !sel_valid || age_expired(int'(sel_age), WINDOW);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= fire;
            if (fire) begin
                res_q.bank <= bank;
                res_q.prio <= idle;
            end
        end
    end

    assign res_valid = res_q.valid;
    assign res_bank  = res_q.bank;
    assign res_prio  = res_q.prio;

    a_r5_result_follows_head: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> res_valid == $past(fire));

    a_r10_bank_echo: assert property (@(posedge clk) disable iff (rst)
        $past(fire) && !$past(rst) |-> res_bank == $past(bank));

endmodule

// File: rtl/bank_idle_table.sv
module bank_idle_table #(
    parameter int unsigned NUM_BANKS = bht_pkg::DEF_NUM_BANKS,
    parameter int unsigned WINDOW    = bht_pkg::DEF_WINDOW,
    localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int unsigned CNT_W    = bht_pkg::time_width(WINDOW, NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_valid,
    input  logic              upd_head,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic              lk_valid,
    input  logic              lk_head,
    input  logic [BANK_W-1:0] lk_bank,
    output logic              res_valid,
    output logic [BANK_W-1:0] res_bank,
    output logic              res_prio
);

    logic [CNT_W-1:0]                now;
    logic [BANK_W-1:0]               sweep_ptr;
    logic [NUM_BANKS-1:0]            valid_vec;
    logic [NUM_BANKS-1:0][CNT_W-1:0] stamp_vec;
    logic                            upd_fire;
    logic                            lk_fire;

    assign upd_fire = upd_valid && upd_head;
    assign lk_fire  = lk_valid && lk_head;

    bht_timebase #(
        .NUM_BANKS (NUM_BANKS),
        .CNT_W     (CNT_W)
    ) u_time (
        .clk       (clk),
        .rst       (rst),
        .now       (now),
        .sweep_ptr (sweep_ptr)
    );

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_entry
        logic hit_i;
        logic swept_i;
        assign hit_i   = upd_fire && (int'(upd_bank) == gi);
        assign swept_i = (int'(sweep_ptr) == gi);

        bht_entry #(
            .NUM_BANKS (NUM_BANKS),
            .WINDOW    (WINDOW),
            .CNT_W     (CNT_W)
        ) u_ent (
            .clk     (clk),
            .rst     (rst),
            .now     (now),
            .hit     (hit_i),
            .swept   (swept_i),
            .valid_q (valid_vec[gi]),
            .stamp_q (stamp_vec[gi])
        );
    end

    bht_lookup #(
        .NUM_BANKS (NUM_BANKS),
        .WINDOW    (WINDOW),
        .CNT_W     (CNT_W)
    ) u_look (
        .clk       (clk),
        .rst       (rst),
        .now       (now),
        .valid_vec (valid_vec),
        .stamp_vec (stamp_vec),
        .fire      (lk_fire),
        .bank      (lk_bank),
        .res_valid (res_valid),
        .res_bank  (res_bank),
        .res_prio  (res_prio)
    );

    // R6: a colliding lookup of an empty entry still reports idle
    a_r6_lookup_before_update: assert property (@(posedge clk) disable iff (rst)
        lk_fire && upd_fire && (lk_bank == upd_bank) && !valid_vec[lk_bank]
        |=> res_prio);

    // R2: a lookup right after an update of the same bank reports busy
    a_r2_recent_busy: assert property (@(posedge clk) disable iff (rst)
        res_valid && $past(upd_fire, 2) && !$past(rst, 2)
        && ($past(upd_bank, 2) == res_bank) |-> !res_prio);

endmodule

// File: tb/sim_bank_idle_table.sv
module sim_bank_idle_table;

    localparam int NB     = 64;
    localparam int WIN    = 200;
    localparam int BW     = $clog2(NB);
    localparam int WRAP   = 1 << ($clog2(WIN + NB) + 1);
    localparam int CLK_NS = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          upd_valid = 1'b0, upd_head = 1'b0;
    logic [BW-1:0] upd_bank = '0;
    logic          lk_valid = 1'b0, lk_head = 1'b0;
    logic [BW-1:0] lk_bank = '0;
    logic          res_valid, res_prio;
    logic [BW-1:0] res_bank;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    int    q_bank[$];
    bit    q_prio[$];
    string q_tag[$];

    bank_idle_table #(.NUM_BANKS(NB), .WINDOW(WIN)) u0 (
        .clk(clk), .rst(rst),
        .upd_valid(upd_valid), .upd_head(upd_head), .upd_bank(upd_bank),
        .lk_valid(lk_valid), .lk_head(lk_head), .lk_bank(lk_bank),
        .res_valid(res_valid), .res_bank(res_bank), .res_prio(res_prio)
    );

    always #(CLK_NS/2) clk = ~clk;

    // bench cycle count mirrors the age reference: stamp = cyc at issue
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // monitor: pop expectations as results appear
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            checks++;
            if (q_bank.size() == 0) begin
                errors++;
                $display("FAIL R5: unexpected result bank=%0d prio=%0d, expected none",
                         res_bank, res_prio);
            end else begin
                automatic int    eb = q_bank.pop_front();
                automatic bit    ep = q_prio.pop_front();
                automatic string et = q_tag.pop_front();
                if (int'(res_bank) != eb || res_prio != ep) begin
                    errors++;
                    $display("FAIL %s: bank=%0d prio=%0d, expected bank=%0d prio=%0d",
                             et, res_bank, res_prio, eb, ep);
                end
            end
        end
    end

    task automatic go_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic drive(input bit do_upd, input bit uhead, input int ub,
                         input bit do_lk, input bit lhead, input int lb,
                         input bit exp, input string tag);
        upd_valid = do_upd; upd_head = uhead; upd_bank = BW'(ub);
        lk_valid  = do_lk;  lk_head  = lhead; lk_bank  = BW'(lb);
        if (do_lk && lhead) begin
            q_bank.push_back(lb); q_prio.push_back(exp); q_tag.push_back(tag);
        end
        @(negedge clk);
        upd_valid = 1'b0; upd_head = 1'b0; lk_valid = 1'b0; lk_head = 1'b0;
    endtask

    task automatic upd(input int b, output int stamp);
        stamp = cyc;
        drive(1, 1, b, 0, 0, 0, 0, "");
    endtask

    task automatic look(input int b, input bit exp, input string tag);
        drive(0, 0, 0, 1, 1, b, exp, tag);
    endtask

    initial begin
        int s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: everything idle out of reset
        look(0, 1, "R1");
        look(37, 1, "R1");
        look(NB-1, 1, "R1");

        // R2 / R3: window edges for bank 5
        upd(5, s);
        go_to(s + 1);        look(5, 0, "R2");
        go_to(s + WIN - 1);  look(5, 0, "R2");
        go_to(s + WIN);      look(5, 1, "R3");

        // R4: body/tail update is ignored
        drive(1, 0, 9, 0, 0, 0, 0, "");
        look(9, 1, "R4");

        // R5: non-head lookup yields no result
        drive(0, 0, 0, 1, 0, 5, 0, "");
        checks++;
        if (res_valid) begin
            errors++;
            $display("FAIL R5: res_valid=%0d after body lookup, expected 0", res_valid);
        end

        // R6: same-cycle update and lookup see the old state
        drive(1, 1, 12, 1, 1, 12, 1, "R6");
        look(12, 0, "R6");

        // R7: neighbours untouched
        upd(20, s);
        go_to(s + 2); look(21, 1, "R7");
        look(19, 1, "R7");
        look(20, 0, "R7");

        // R8: re-update restarts the window
        upd(30, s);
        go_to(s + WIN - 10);
        upd(30, s);
        go_to(s + WIN - 5); look(30, 0, "R8");
        go_to(s + WIN);     look(30, 1, "R8");

        // R9: age beyond one counter wrap must not alias to busy
        upd(40, s);
        go_to(s + WRAP + 5); look(40, 1, "R9");

        // R10: back-to-back lookups, ordered, each echoing its bank
        upd(50, s);
        look(50, 0, "R10");
        look(51, 1, "R10");
        look(50, 0, "R10");
        look(2, 1, "R10");

        repeat (4) @(negedge clk);
        checks++;
        if (q_bank.size() != 0) begin
            errors++;
            $display("FAIL R5: %0d results missing, expected 0", q_bank.size());
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R5: watchdog expired, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule